// File: doc/BRIEF.md
# SCSI Controller Register and Command Interface

This block is the host-facing register file and command decoder of a small SCSI protocol controller. A processor reaches sixteen byte registers through a word-indexed bus (one register every four bytes, so the port carries address bits [5:2]). Every register has a read image and a write image, and the two are stored apart. A byte written to the command register is decoded at once. The decoder then updates the status, interrupt and sequence-step registers and fires a one-cycle strobe to the transfer engine or to the FIFO block. The five strobes are transfer start, select with attention, select with attention and stop, status response and flush.

The transfer engine reports progress back through a single report strobe that loads status, interrupt and sequence values. The block keeps a level interrupt line. The line stays high until software reads the interrupt register, and that read also clears the pending, gross-error and parity-error status bits. Bit 7 of any command byte selects DMA mode. It also copies the last written transfer count into the count read registers.

Top module: `scsi_regif`

## Requirements
- R1: The bus port addr_i carries the register index (byte address bits [5:2]) and selects one of 16 byte registers. A read registers the selected read image onto rdata_o in the cycle after rd_i, and rdata_o holds its value while rd_i is low.
- R2: After rst_ni is released, every register reads 0x00 except index 14, which reads 0x04. irq_o, dma_o and all strobes are low.
- R3: A write to index 8 or to indices 12 to 15 is returned by a later read of the same index. A write to index 11 reads back ANDed with 0x15. Writes to indices 2, 7, 9 and 10 have no effect, and those indices read 0x00.
- R4: A read of index 5 (interrupt register) returns its value from before the read. It then clears status bits 7, 6 and 5 (masks 0x80, 0x40, 0x20) of index 4, leaves the other status bits, and drops irq_o the next cycle.
- R5: A command byte with bit 7 set raises dma_o and loads read indices 0 and 1 from the bytes last written to indices 0 and 1. A command byte with bit 7 clear lowers dma_o and leaves indices 0 and 1 as they were. Writes to indices 0 and 1 alone do not change what those indices read.
- R6: Command 0x01 sets the interrupt register to 0x08, sets the sequence register (index 6) to 0 and pulses flush_o.
- R7: Command 0x02 returns every register, irq_o and dma_o to the reset state of R2 and issues no strobe. This includes the command read image and a pending DMA reload.
- R8: Command 0x03 sets the interrupt register to 0x80. Only when bit 6 of index 8 is 0 does it also raise irq_o and set status bit 7.
- R9: A write to index 0 or 1 clears status bit 4 (terminal count, 0x10).
- R10: The command read image (index 3) holds the last command byte. An unknown code, such as 0x55, changes nothing else and issues no strobe.
- R11: Strobes are high for exactly the cycle after the command write, and at most one at a time. 0x10 pulses xfer_start_o and, with bit 7 set, clears status bit 4. 0x42 pulses sel_atn_o. 0x43 pulses sel_atn_stop_o. 0x11 pulses status_resp_o. 0x12 pulses status_resp_o and sets the interrupt register to 0x20 and the sequence register to 0. Both 0x11 and 0x12 raise irq_o and status bit 7.
- R12: A report pulse on evt_i loads index 4 with evt_stat_i, index 5 with evt_intr_i and index 6 with evt_seq_i. It raises irq_o when evt_stat_i bit 7 is set and leaves irq_o alone otherwise.
- R13: Once raised, irq_o stays high, whatever else happens on the bus, until index 5 is read or the chip is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register index (byte address bits [5:2]) |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| rd_i | input | 1 | Read strobe, sampled on the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after rd_i |
| evt_i | input | 1 | Transfer engine report strobe |
| evt_stat_i | input | 8 | Reported status value |
| evt_intr_i | input | 8 | Reported interrupt value |
| evt_seq_i | input | 3 | Reported sequence step |
| irq_o | output | 1 | Level interrupt request |
| dma_o | output | 1 | DMA mode selected by the last command |
| xfer_start_o | output | 1 | Start transfer strobe |
| sel_atn_o | output | 1 | Select with attention strobe |
| sel_atn_stop_o | output | 1 | Select with attention and stop strobe |
| status_resp_o | output | 1 | Status response strobe |
| flush_o | output | 1 | FIFO flush strobe |

## Verification
Each register effect of a write or a report becomes visible at the first edge after the strobe. The bench reads it back with a later bus read. That read's data is due one cycle after its strobe, and a monitor compares it at the falling edge that follows. Command strobes, irq_o and dma_o are registered at that same first edge. The bench samples them at the falling edge right after the write cycle, and again one cycle later to confirm the strobe is gone. Expected read values wait in a queue in issue order, so every comparison lines up with the read that produced it.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;
  localparam int NUM_REGS  = 16;
  localparam int IDX_CNT_L = 0;
  localparam int IDX_CNT_H = 1;
  localparam int IDX_CMD   = 3;
  localparam int IDX_STAT  = 4;
  localparam int IDX_INTR  = 5;
  localparam int IDX_SEQ   = 6;
  localparam int IDX_CFG   = 8;
  localparam int IDX_CFG3  = 11;
  localparam int IDX_ID    = 14;

  localparam logic [7:0] INTR_FUNC_DONE = 8'h08;
  localparam logic [7:0] INTR_DISC      = 8'h20;
  localparam logic [7:0] INTR_BUS_RST   = 8'h80;

  localparam int ST_TC  = 4;
  localparam int ST_INT = 7;
  localparam logic [7:0] ST_RD_CLR = 8'hE0;

  typedef struct packed {
    logic dma;
    logic flush;
    logic chip_rst;
    logic bus_rst;
    logic xfer;
    logic satn;
    logic satn_stop;
    logic resp;
    logic msg_acc;
  } cmd_t;

  typedef struct packed {
    logic xfer;
    logic satn;
    logic satn_stop;
    logic resp;
    logic flush;
  } strb_t;
endpackage

// File: rtl/scsi_cmd_dec.sv
module scsi_cmd_dec
  import scsi_regif_pkg::*;
(
  input  logic [7:0] cmd_i,
  output cmd_t       dec_o
);
  always_comb begin
    dec_o     = '0;
    dec_o.dma = cmd_i[7];
    unique case (cmd_i[6:0])
      7'h01:   dec_o.flush     = 1'b1;
      7'h02:   dec_o.chip_rst  = 1'b1;
      7'h03:   dec_o.bus_rst   = 1'b1;
      7'h10:   dec_o.xfer      = 1'b1;
      7'h11:   dec_o.resp      = 1'b1;
      7'h12:   dec_o.msg_acc   = 1'b1;
      7'h42:   dec_o.satn      = 1'b1;
      7'h43:   dec_o.satn_stop = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/scsi_shadow_reg.sv
module scsi_shadow_reg #(
  parameter int IDX_W = 4,
  parameter int IDX   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             q_o <= '0;
    else if (wr_i && int'(idx_i) == IDX)     q_o <= wdata_i;
    else if (clr_i)                          q_o <= '0;
  end
endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
  import scsi_regif_pkg::*;
#(
  parameter int         ADDR_W    = 6,
  parameter logic [7:0] ID_VAL    = 8'h04,
  parameter logic [7:0] CFG3_MASK = 8'h15,
  parameter int         SEQ_W     = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:2]   addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic                evt_i,
  input  logic [7:0]          evt_stat_i,
  input  logic [7:0]          evt_intr_i,
  input  logic [SEQ_W-1:0]    evt_seq_i,
  output logic                irq_o,
  output logic                dma_o,
  output logic                xfer_start_o,
  output logic                sel_atn_o,
  output logic                sel_atn_stop_o,
  output logic                status_resp_o,
  output logic                flush_o
);
  localparam int IDX_W    = ADDR_W - 2;
  localparam int N_SHADOW = 2;

  logic [7:0] rv_q [NUM_REGS];
  logic [7:0] rv_d [NUM_REGS];
  logic [7:0] cnt_wr [N_SHADOW];
  logic       irq_q, irq_d, dma_q, dma_d;
  strb_t      strb_q, strb_d;
  cmd_t       cmd;
  logic       chip_clr;
  logic [7:0] rdata_q;

  scsi_cmd_dec i_dec (.cmd_i(wdata_i), .dec_o(cmd));

  // write images of the transfer count, copied on DMA commands
  for (genvar g = 0; g < N_SHADOW; g++) begin : g_shadow
    scsi_shadow_reg #(.IDX_W(IDX_W), .IDX(IDX_CNT_L + g)) i_shadow (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (chip_clr),
      .wr_i   (wr_i),
      .idx_i  (addr_i),
      .wdata_i(wdata_i),
      .q_o    (cnt_wr[g])
    );
  end

  assign chip_clr = wr_i && int'(addr_i) == IDX_CMD && cmd.chip_rst;

  always_comb begin
    rv_d   = rv_q;
    irq_d  = irq_q;
    dma_d  = dma_q;
    strb_d = '0;
    // engine report first; bus effects of the same cycle override it
    if (evt_i) begin
      rv_d[IDX_STAT] = evt_stat_i;
      rv_d[IDX_INTR] = evt_intr_i;
      rv_d[IDX_SEQ]  = 8'(evt_seq_i);
      if (evt_stat_i[ST_INT]) irq_d = 1'b1;
    end
    if (wr_i) begin
      case (int'(addr_i))
        IDX_CNT_L, IDX_CNT_H: rv_d[IDX_STAT][ST_TC] = 1'b0;
        IDX_CMD: begin
          rv_d[IDX_CMD] = wdata_i;
          dma_d         = cmd.dma;
          if (cmd.dma) begin
            for (int s = 0; s < N_SHADOW; s++) rv_d[IDX_CNT_L + s] = cnt_wr[s];
          end
          if (cmd.flush) begin
            rv_d[IDX_INTR] = INTR_FUNC_DONE;
            rv_d[IDX_SEQ]  = '0;
            strb_d.flush   = 1'b1;
          end
          if (cmd.bus_rst) begin
            rv_d[IDX_INTR] = INTR_BUS_RST;
            if (!rv_q[IDX_CFG][6]) begin
              irq_d                = 1'b1;
              rv_d[IDX_STAT][ST_INT] = 1'b1;
            end
          end
          if (cmd.xfer) begin
            strb_d.xfer = 1'b1;
            if (cmd.dma) rv_d[IDX_STAT][ST_TC] = 1'b0;
          end
          strb_d.satn      = cmd.satn;
          strb_d.satn_stop = cmd.satn_stop;
          if (cmd.resp || cmd.msg_acc) begin
            strb_d.resp            = 1'b1;
            irq_d                  = 1'b1;
            rv_d[IDX_STAT][ST_INT] = 1'b1;
          end
          if (cmd.msg_acc) begin
            rv_d[IDX_INTR] = INTR_DISC;
            rv_d[IDX_SEQ]  = '0;
          end
          if (cmd.chip_rst) begin
            for (int r = 0; r < NUM_REGS; r++) rv_d[r] = (r == IDX_ID) ? ID_VAL : 8'h00;
            irq_d = 1'b0;
            dma_d = 1'b0;
          end
        end
        IDX_CFG, 12, 13, 14, 15: rv_d[addr_i] = wdata_i;
        IDX_CFG3:                rv_d[IDX_CFG3] = wdata_i & CFG3_MASK;
        default: ;
      endcase
    end
    if (rd_i && int'(addr_i) == IDX_INTR) begin
      rv_d[IDX_STAT] = rv_d[IDX_STAT] & ~ST_RD_CLR;
      irq_d          = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) rv_q[r] <= (r == IDX_ID) ? ID_VAL : 8'h00;
      irq_q   <= 1'b0;
      dma_q   <= 1'b0;
      strb_q  <= '0;
      rdata_q <= '0;
    end else begin
      rv_q   <= rv_d;
      irq_q  <= irq_d;
      dma_q  <= dma_d;
      strb_q <= strb_d;
      if (rd_i) rdata_q <= rv_q[addr_i];
    end
  end

  assign rdata_o        = rdata_q;
  assign irq_o          = irq_q;
  assign dma_o          = dma_q;
  assign xfer_start_o   = strb_q.xfer;
  assign sel_atn_o      = strb_q.satn;
  assign sel_atn_stop_o = strb_q.satn_stop;
  assign status_resp_o  = strb_q.resp;
  assign flush_o        = strb_q.flush;
endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:2] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic              evt_i,
  input logic [7:0]        rdata_o,
  input logic              irq_o,
  input logic              dma_o,
  input logic              xfer_start_o,
  input logic              sel_atn_o,
  input logic              sel_atn_stop_o,
  input logic              status_resp_o,
  input logic              flush_o
);
  p_irq_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && int'(addr_i) == 5) |=> !irq_o);

  p_rdata_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_strobe_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({xfer_start_o, sel_atn_o, sel_atn_stop_o, status_resp_o, flush_o}));

  p_strobe_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_o || sel_atn_o || sel_atn_stop_o || status_resp_o || flush_o)
      |-> $past(wr_i));

  p_dma_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(dma_o));

  p_irq_level_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_i && !wr_i) |=> irq_o);

  p_irq_rise_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(wr_i || evt_i));
endmodule

bind scsi_regif scsi_regif_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_scsi_regif.sv
module test_scsi_regif;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, evt = 1'b0;
  logic [7:0] wdata = '0, evt_stat = '0, evt_intr = '0;
  logic [2:0] evt_seq = '0;
  logic [7:0] rdata;
  logic       irq, dma, s_xfer, s_satn, s_stop, s_resp, s_flush;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [7:0] d; string tag; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_regif i_scsi_regif (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .evt_stat_i(evt_stat),
    .evt_intr_i(evt_intr), .evt_seq_i(evt_seq), .irq_o(irq), .dma_o(dma),
    .xfer_start_o(s_xfer), .sel_atn_o(s_satn), .sel_atn_stop_o(s_stop),
    .status_resp_o(s_resp), .flush_o(s_flush)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one cycle after each sampled read strobe
  initial begin
    forever begin
      logic seen;
      @(posedge clk);
      seen = rd;
      @(negedge clk);
      if (seen) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rdata, e.d, e.tag);
      end
    end
  end

  task automatic bus_wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    addr = 4'(idx); wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input int idx, input logic [7:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    addr = 4'(idx); rd = 1'b1;
    e.d = exp; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic report(input logic [7:0] st, input logic [7:0] it, input logic [2:0] sq);
    @(negedge clk);
    evt = 1'b1; evt_stat = st; evt_intr = it; evt_seq = sq;
    @(posedge clk);
    @(negedge clk);
    evt = 1'b0;
  endtask

  function automatic logic [7:0] strb();
    return {3'b0, s_xfer, s_satn, s_stop, s_resp, s_flush};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk({7'b0, irq}, 8'h00, "R2 irq after reset");
    chk({7'b0, dma}, 8'h00, "R2 dma after reset");
    chk(strb(), 8'h00, "R2 strobes after reset");
    bus_rd(14, 8'h04, "R2 id register");
    bus_rd(4, 8'h00, "R2 status");
    bus_rd(0, 8'h00, "R2 count low");
    bus_rd(8, 8'h00, "R2 config");
    // R1 read data holds while idle
    repeat (3) @(negedge clk);
    chk(rdata, 8'h00, "R1 rdata holds");

    // R3 plain registers
    bus_wr(8, 8'h5A);  bus_rd(8, 8'h5A, "R3 config readback");
    bus_wr(11, 8'hFF); bus_rd(11, 8'h15, "R3 masked index 11");
    bus_wr(12, 8'hA5); bus_rd(12, 8'hA5, "R3 index 12");
    bus_wr(14, 8'h3C); bus_rd(14, 8'h3C, "R3 index 14");
    bus_wr(9, 8'h77);  bus_rd(9, 8'h00, "R3 index 9 ignored");
    bus_wr(2, 8'h66);  bus_rd(2, 8'h00, "R3 index 2 ignored");

    // R5 count reload and DMA mode
    bus_wr(0, 8'h34); bus_wr(1, 8'h12);
    bus_rd(0, 8'h00, "R5 count not loaded by plain write");
    bus_wr(3, 8'h80);
    chk({7'b0, dma}, 8'h01, "R5 dma set");
    bus_rd(0, 8'h34, "R5 count low reloaded");
    bus_rd(1, 8'h12, "R5 count high reloaded");
    bus_rd(3, 8'h80, "R10 command image");
    bus_wr(0, 8'h01);
    bus_wr(3, 8'h00);
    chk({7'b0, dma}, 8'h00, "R5 dma cleared");
    bus_rd(0, 8'h34, "R5 count kept without bit 7");

    // R12 engine report, R9 terminal count clear, R4 clear on read
    report(8'h93, 8'h18, 3'd4);
    chk({7'b0, irq}, 8'h01, "R12 irq raised by report");
    bus_rd(4, 8'h93, "R12 status loaded");
    bus_rd(6, 8'h04, "R12 sequence loaded");
    bus_wr(1, 8'h12);
    bus_rd(4, 8'h83, "R9 terminal count cleared");
    chk({7'b0, irq}, 8'h01, "R13 irq held across bus traffic");
    bus_rd(5, 8'h18, "R4 interrupt value before clear");
    chk({7'b0, irq}, 8'h00, "R4 irq dropped");
    bus_rd(4, 8'h03, "R4 status bits cleared");
    report(8'h61, 8'h00, 3'd0);
    chk({7'b0, irq}, 8'h00, "R12 no irq without bit 7");
    bus_rd(5, 8'h00, "R4 interrupt read");
    bus_rd(4, 8'h01, "R4 error bits cleared");

    // R6 flush
    bus_wr(3, 8'h01);
    chk(strb(), 8'h01, "R6 flush strobe");
    @(negedge clk);
    chk(strb(), 8'h00, "R11 strobe one cycle");
    bus_rd(5, 8'h08, "R6 function complete");
    bus_rd(6, 8'h00, "R6 sequence zero");

    // R8 bus reset, masked then unmasked
    bus_wr(3, 8'h03);
    chk({7'b0, irq}, 8'h00, "R8 masked bus reset no irq");
    bus_rd(5, 8'h80, "R8 interrupt bus reset");
    bus_rd(4, 8'h01, "R8 masked no status bit 7");
    bus_wr(8, 8'h00);
    bus_wr(3, 8'h03);
    repeat (5) @(negedge clk);
    chk({7'b0, irq}, 8'h01, "R13 irq level held");
    bus_rd(4, 8'h81, "R8 status bit 7 set");
    bus_rd(5, 8'h80, "R8 interrupt value");
    chk({7'b0, irq}, 8'h00, "R13 irq cleared by read");

    // R11 command strobes
    bus_wr(3, 8'h10); chk(strb(), 8'h10, "R11 transfer strobe");
    bus_wr(3, 8'h42); chk(strb(), 8'h08, "R11 select atn strobe");
    bus_wr(3, 8'h43); chk(strb(), 8'h04, "R11 select atn stop strobe");
    bus_wr(3, 8'h11); chk(strb(), 8'h02, "R11 status response strobe");
    chk({7'b0, irq}, 8'h01, "R11 response raises irq");
    bus_rd(5, 8'h80, "R11 interrupt unchanged by 0x11");
    bus_wr(3, 8'h12); chk(strb(), 8'h02, "R11 message accept strobe");
    bus_rd(5, 8'h20, "R11 disconnect");
    bus_rd(6, 8'h00, "R11 sequence zero");
    report(8'h10, 8'h00, 3'd2);
    bus_wr(3, 8'h90);
    chk(strb(), 8'h10, "R11 dma transfer strobe");
    chk({7'b0, dma}, 8'h01, "R5 dma by transfer");
    bus_rd(4, 8'h00, "R11 dma transfer clears TC");

    // R10 unknown command
    bus_wr(3, 8'h55);
    chk(strb(), 8'h00, "R10 unknown no strobe");
    chk({7'b0, dma}, 8'h00, "R10 unknown dma cleared by bit 7");
    bus_rd(3, 8'h55, "R10 command image unknown");
    bus_rd(5, 8'h00, "R10 interrupt unchanged");
    bus_rd(6, 8'h02, "R10 sequence unchanged");

    // R7 chip reset command
    bus_wr(3, 8'h80);
    report(8'h80, 8'h10, 3'd1);
    bus_wr(3, 8'h02);
    chk(strb(), 8'h00, "R7 no strobe");
    chk({7'b0, irq}, 8'h00, "R7 irq cleared");
    chk({7'b0, dma}, 8'h00, "R7 dma cleared");
    bus_rd(12, 8'h00, "R7 index 12 cleared");
    bus_rd(14, 8'h04, "R7 id restored");
    bus_rd(3, 8'h00, "R7 command image cleared");
    bus_rd(0, 8'h00, "R7 count cleared");
    bus_rd(5, 8'h00, "R7 interrupt cleared");
    bus_wr(3, 8'h80);
    bus_rd(0, 8'h00, "R7 count write image cleared");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule